// File: doc/BRIEF.md
# Shortened Reed-Solomon Systematic Encoder (9-bit symbols, 450/406)

This block turns a stream of 406 nine-bit data symbols into a 450-symbol systematic codeword. Each accepted data symbol is forwarded to the output one clock later, unchanged. At the same time it is folded into a 44-stage remainder register. Once the final data symbol has gone through, the block spends 44 clocks draining that register, so the check symbols follow the data directly. The code is built over the 512-element field generated by x^9 + x^4 + 1. Its generator polynomial has roots alpha^0 through alpha^43, so the code can repair up to 22 corrupted symbols per block.

An upstream source marks the first data symbol of each block with a start flag and offers symbols with a valid strobe. Gaps in the data are allowed. The ready output is low only while check symbols are leaving. A new block may begin on the clock right after the last check symbol. The output side carries a valid strobe, a start flag on the first data symbol and a flag that marks check symbols.

Top module: `rs450_encoder`

## Requirements
- R1: The 44 check symbols equal the remainder of m(x)·x^44 divided by g(x) = (x+alpha^0)(x+alpha^1)…(x+alpha^43). Here alpha is a root of x^9+x^4+1, so alpha^9 = 0x011. The first data symbol is the highest-degree coefficient of m(x). An all-zero message gives all-zero check symbols.
- R2: Each accepted data symbol appears on out_sym_o with out_valid_o high and out_par_o low, exactly one clock after the edge that accepts it, in arrival order.
- R3: out_sop_o is high only with the first data symbol of a block and never with a check symbol.
- R4: After the 406th data symbol, exactly 44 check symbols follow on consecutive clocks with out_par_o high, from the highest-degree remainder coefficient down to the lowest.
- R5: in_ready_o is low on every clock where a check symbol is still to be sent. Input offered during that time, including a start flag, produces no output and does not disturb the codeword.
- R6: in_ready_o returns high on the clock after the last check symbol is sent, and a block may start there back to back.
- R7: A start flag received in the middle of a block discards the partial remainder and begins a new block from that symbol. The symbols already forwarded stay on the output.
- R8: A valid symbol that arrives without a start flag while no block is open is dropped and produces no output.
- R9: While reset is held low, in_ready_o is high and out_valid_o and out_par_o are low.
- R10: A clock in the data phase with in_valid_i low produces no output on the next clock and does not advance the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input symbol offered |
| in_sop_i | input | 1 | Offered symbol opens a new block |
| in_sym_i | input | 9 | Data symbol |
| in_ready_o | output | 1 | High when data symbols are accepted |
| out_valid_o | output | 1 | Output symbol present |
| out_sop_o | output | 1 | Output symbol is the first of a codeword |
| out_par_o | output | 1 | Output symbol is a check symbol |
| out_sym_o | output | 9 | Output symbol |

## Verification
A corrupted remainder stage only becomes visible once the block drains. The bench therefore compares every check symbol against a long division carried out in the bench, and a single flipped stage shows up at its own position within 44 clocks of the last data symbol. A miscounted data phase moves the start of the check run and shifts the whole codeword. The comparison catches this at the first symbol that is out of place. Errors in control, such as accepting input while check symbols leave or dropping a gap, appear on the very next clock as an extra or missing output strobe.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    // Operating phase of the encoder: taking data, or draining check symbols.
    typedef enum logic {
        PH_MSG = 1'b0,
        PH_PAR = 1'b1
    } rs_phase_e;

endpackage

// File: rtl/rs_gf_cmul.sv
// Multiplies a field element by a constant in GF(2^SYM_W).
// Shift-and-add from the top coefficient bit, reducing on each shift.
module rs_gf_cmul #(
    parameter int                SYM_W = 9,
    parameter logic [SYM_W-1:0]  RED   = 9'h011,
    parameter logic [SYM_W-1:0]  COEF  = 9'h001
) (
    input  logic [SYM_W-1:0] a_i,
    output logic [SYM_W-1:0] p_o
);

    logic [SYM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int b = SYM_W - 1; b >= 0; b--) begin
            acc = {acc[SYM_W-2:0], 1'b0} ^ (acc[SYM_W-1] ? RED : '0);
            if (COEF[b]) begin
                acc = acc ^ a_i;
            end
        end
        p_o = acc;
    end

endmodule

// File: rtl/rs_parity_chain.sv
// Remainder register of the systematic encoder with constant multipliers.
// The generator coefficients are computed at elaboration from RED.
module rs_parity_chain #(
    parameter int               SYM_W   = 9,
    parameter int               PAR_LEN = 44,
    parameter logic [SYM_W-1:0] RED     = 9'h011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,    // treat stored remainder as zero
    input  logic             step_i,   // advance the chain
    input  logic             fb_en_i,  // feedback open (data phase)
    input  logic [SYM_W-1:0] din_i,
    output logic [SYM_W-1:0] tail_o
);

    localparam int CW = PAR_LEN * SYM_W;

    function automatic logic [SYM_W-1:0] f_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            acc = {acc[SYM_W-2:0], 1'b0} ^ (acc[SYM_W-1] ? RED : '0);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // Expand the product of (x + alpha^i), i = 0 .. PAR_LEN-1.
    function automatic logic [CW-1:0] f_genpoly();
        logic [PAR_LEN:0][SYM_W-1:0] g;
        logic [SYM_W-1:0]            root;
        g    = '0;
        g[0] = SYM_W'(1);
        root = SYM_W'(1);
        for (int i = 0; i < PAR_LEN; i++) begin
            for (int j = PAR_LEN; j > 0; j--) begin
                g[j] = g[j-1] ^ f_mul(g[j], root);
            end
            g[0] = f_mul(g[0], root);
            root = f_mul(root, SYM_W'(2));
        end
        return g[PAR_LEN-1:0];
    endfunction

    localparam logic [CW-1:0] GEN = f_genpoly();

    logic [PAR_LEN-1:0][SYM_W-1:0] par_d, par_q;
    logic [PAR_LEN-1:0][SYM_W-1:0] cur;
    logic [PAR_LEN-1:0][SYM_W-1:0] prod;
    logic [SYM_W-1:0]              fb;

    always_comb begin
        cur = clr_i ? '0 : par_q;
    end

    always_comb begin
        fb = fb_en_i ? (din_i ^ cur[PAR_LEN-1]) : '0;
    end

    for (genvar j = 0; j < PAR_LEN; j++) begin : g_tap
        rs_gf_cmul #(
            .SYM_W (SYM_W),
            .RED   (RED),
            .COEF  (GEN[j*SYM_W +: SYM_W])
        ) u_mul (
            .a_i (fb),
            .p_o (prod[j])
        );
    end

    always_comb begin
        par_d = par_q;
        if (step_i) begin
            par_d[0] = prod[0];
            for (int j = 1; j < PAR_LEN; j++) begin
                par_d[j] = cur[j-1] ^ prod[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign tail_o = par_q[PAR_LEN-1];

endmodule

// File: rtl/rs450_encoder.sv
module rs450_encoder
    import rs_enc_pkg::*;
#(
    parameter int               SYM_W   = 9,
    parameter int               MSG_LEN = 406,
    parameter int               PAR_LEN = 44,
    parameter logic [SYM_W-1:0] RED     = 9'h011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             in_sop_i,
    input  logic [SYM_W-1:0] in_sym_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic             out_sop_o,
    output logic             out_par_o,
    output logic [SYM_W-1:0] out_sym_o
);

    localparam int MAXC  = (MSG_LEN > PAR_LEN) ? MSG_LEN : PAR_LEN;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        rs_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic             ovld;
        logic             osop;
        logic             opar;
        logic [SYM_W-1:0] osym;
    } st_t;

    st_t              st_d, st_q;
    logic             take;
    logic [CNT_W-1:0] cnt_nx;
    logic [SYM_W-1:0] tail;

    // A symbol is taken in the data phase if it opens a block or one is open.
    assign take = in_valid_i && (st_q.phase == PH_MSG)
                  && (in_sop_i || (st_q.cnt != '0));

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        st_d.osop = 1'b0;
        st_d.opar = 1'b0;
        cnt_nx    = in_sop_i ? CNT_W'(1) : st_q.cnt + CNT_W'(1);
        case (st_q.phase)
            PH_MSG: begin
                if (take) begin
                    st_d.ovld = 1'b1;
                    st_d.osop = in_sop_i;
                    st_d.osym = in_sym_i;
                    st_d.cnt  = cnt_nx;
                    if (cnt_nx == CNT_W'(MSG_LEN)) begin
                        st_d.phase = PH_PAR;
                        st_d.cnt   = '0;
                    end
                end
            end
            default: begin
                st_d.ovld = 1'b1;
                st_d.opar = 1'b1;
                st_d.osym = tail;
                if (st_q.cnt == CNT_W'(PAR_LEN - 1)) begin
                    st_d.phase = PH_MSG;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rs_parity_chain #(
        .SYM_W   (SYM_W),
        .PAR_LEN (PAR_LEN),
        .RED     (RED)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (take && in_sop_i),
        .step_i  (take || (st_q.phase == PH_PAR)),
        .fb_en_i (st_q.phase == PH_MSG),
        .din_i   (in_sym_i),
        .tail_o  (tail)
    );

    assign in_ready_o  = (st_q.phase == PH_MSG);
    assign out_valid_o = st_q.ovld;
    assign out_sop_o   = st_q.osop;
    assign out_par_o   = st_q.opar;
    assign out_sym_o   = st_q.osym;

endmodule

// File: rtl/rs450_encoder_chk.sv
module rs450_encoder_chk #(
    parameter int SYM_W   = 9,
    parameter int PAR_LEN = 44
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid_i,
    input logic             in_sop_i,
    input logic [SYM_W-1:0] in_sym_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_sop_o,
    input logic             out_par_o,
    input logic [SYM_W-1:0] out_sym_o
);

    localparam int RW = $clog2(PAR_LEN + 1) + 1;

    // Check symbols already seen in the current run.
    logic [RW-1:0] par_run;

    always_ff @(posedge clk) begin
        if (!rst_n)         par_run <= '0;
        else if (out_par_o) par_run <= par_run + RW'(1);
        else                par_run <= '0;
    end

    p_par_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_par_o |-> out_valid_o);

    p_par_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_par_o |-> (par_run < RW'(PAR_LEN)));

    p_ready_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_par_o && (par_run < RW'(PAR_LEN - 1))) |-> !in_ready_o);

    p_ready_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_par_o && (par_run == RW'(PAR_LEN - 1))) |-> in_ready_o);

    p_sop_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && in_sop_i) |=>
        (out_valid_o && out_sop_o && !out_par_o && (out_sym_o == $past(in_sym_i))));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !in_valid_i) |=> !out_valid_o);

endmodule

bind rs450_encoder rs450_encoder_chk #(
    .SYM_W   (SYM_W),
    .PAR_LEN (PAR_LEN)
) u_chk (.*);

// File: tb/rs450_encoder_bench.sv
module rs450_encoder_bench;

    localparam int W = 9;
    localparam int K = 406;
    localparam int P = 44;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic         in_sop_i = 1'b0;
    logic [W-1:0] in_sym_i = '0;
    logic         in_ready_o, out_valid_o, out_sop_o, out_par_o;
    logic [W-1:0] out_sym_o;

    always #5 clk = ~clk;

    rs450_encoder u_rs450_encoder (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit prev_gap = 1'b0;

    logic [W-1:0]  gpoly [0:P];
    logic [W-1:0]  msg   [0:K-1];
    logic [W+1:0]  exp_q [$];
    logic [W+1:0]  act_q [$];
    int            stamp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            act_q.push_back({out_sop_o, out_par_o, out_sym_o});
            stamp_q.push_back(cyc);
        end
    end

    function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        logic [W-1:0] s = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) r ^= s;
            s = {s[W-2:0], 1'b0} ^ (s[W-1] ? 9'h011 : 9'h000);
        end
        return r;
    endfunction

    task automatic report(input bit ok, input string req, input string what,
                          input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Build g(x) coefficients gpoly[0..P], gpoly[P] = 1.
    task automatic build_gen();
        logic [W-1:0] root = 9'd1;
        for (int i = 0; i <= P; i++) gpoly[i] = '0;
        gpoly[0] = 9'd1;
        for (int i = 0; i < P; i++) begin
            for (int j = P; j > 0; j--) gpoly[j] = gpoly[j-1] ^ gmul(gpoly[j], root);
            gpoly[0] = gmul(gpoly[0], root);
            root = gmul(root, 9'd2);
        end
    endtask

    // Drive len data symbols from msg[], first one with start flag (R2, R10).
    task automatic send_msg(input int len, input int gap_pct);
        int gap_bad = 0;
        int rdy_bad = 0;
        int gaps    = 0;
        for (int i = 0; i < len; i++) begin
            while ($urandom % 100 < gap_pct) begin
                @(negedge clk);
                if (prev_gap && out_valid_o) gap_bad++;
                in_valid_i = 1'b0;
                in_sop_i   = 1'b0;
                prev_gap   = 1'b1;
                gaps++;
            end
            @(negedge clk);
            if (prev_gap && out_valid_o) gap_bad++;
            prev_gap = 1'b0;
            if (i == 0) report(in_ready_o === 1'b1, "R6", "ready at block start", in_ready_o, 1);
            else if (in_ready_o !== 1'b1) rdy_bad++;
            in_valid_i = 1'b1;
            in_sop_i   = (i == 0);
            in_sym_i   = msg[i];
            exp_q.push_back({(i == 0), 1'b0, msg[i]});
        end
        report(rdy_bad == 0, "R2", "ready lost during data", rdy_bad, 0);
        if (gaps > 0) report(gap_bad == 0, "R10", "output during gap", gap_bad, 0);
    endtask

    // Queue the expected remainder and cover the drain phase (R1, R5).
    task automatic finish_block(input bit junk);
        logic [W-1:0] buff [0:K+P-1];
        int bad = 0;
        for (int i = 0; i < K; i++) buff[i] = msg[i];
        for (int i = K; i < K + P; i++) buff[i] = '0;
        for (int i = 0; i < K; i++) begin
            logic [W-1:0] c = buff[i];
            for (int j = 0; j <= P; j++) buff[i+j] ^= gmul(c, gpoly[P-j]);
        end
        for (int i = 0; i < P; i++) exp_q.push_back({1'b0, 1'b1, buff[K+i]});
        for (int p = 0; p < P; p++) begin
            @(negedge clk);
            if (in_ready_o !== 1'b0) bad++;
            in_valid_i = junk;
            in_sop_i   = junk;
            in_sym_i   = W'($urandom);
        end
        report(bad == 0, "R5", "ready high while draining", bad, 0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < K; i++) msg[i] = W'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        build_gen();
        repeat (3) @(negedge clk);
        // R9: values held during reset
        report(in_ready_o === 1'b1, "R9", "ready in reset", in_ready_o, 1);
        report(out_valid_o === 1'b0, "R9", "valid in reset", out_valid_o, 0);
        report(out_par_o === 1'b0, "R9", "par flag in reset", out_par_o, 0);
        rst_n = 1'b1;

        // R8: stray symbols with no open block
        begin
            int stray = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_valid_o) stray++;
                in_valid_i = 1'b1;
                in_sop_i   = 1'b0;
                in_sym_i   = W'($urandom);
            end
            @(negedge clk);
            if (out_valid_o) stray++;
            in_valid_i = 1'b0;
            @(negedge clk);
            if (out_valid_o) stray++;
            report(stray == 0, "R8", "output from stray input", stray, 0);
        end

        // R1 random block with gaps, junk during drain
        fill_random();
        send_msg(K, 20);
        finish_block(1'b1);
        // R1 all-zero block, back to back (R6)
        for (int i = 0; i < K; i++) msg[i] = '0;
        send_msg(K, 0);
        finish_block(1'b0);
        // R1 single unit in lowest data position: remainder is g(x) minus x^44
        msg[K-1] = 9'd1;
        send_msg(K, 0);
        finish_block(1'b1);
        // R7: aborted block then a fresh one
        fill_random();
        send_msg(60, 10);
        fill_random();
        send_msg(K, 5);
        finish_block(1'b0);
        // R1 all-ones symbols
        for (int i = 0; i < K; i++) msg[i] = 9'h1FF;
        send_msg(K, 30);
        finish_block(1'b0);
        @(negedge clk);
        in_valid_i = 1'b0;
        in_sop_i   = 1'b0;
        repeat (5) @(negedge clk);

        report(act_q.size() == exp_q.size(), "R4", "output symbol count",
               act_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < act_q.size(); i++) begin
            string req = exp_q[i][W] ? "R1" : (exp_q[i][W+1] ? "R3" : "R2");
            report(act_q[i] === exp_q[i], req, $sformatf("symbol %0d {sop,par,sym}", i),
                   act_q[i], exp_q[i]);
            if (exp_q[i][W] && i > 0)
                report(stamp_q[i] == stamp_q[i-1] + 1, "R4",
                       $sformatf("check symbol %0d spacing", i),
                       stamp_q[i] - stamp_q[i-1], 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule